// File: doc/BRIEF.md
# Bidirectional Pin Boundary-Scan Slice

This block is the test-access slice wrapped around one bidirectional port pin that has a weak pull-up. In normal operation the pad follows the port's own registers. The direction bit turns on the output driver, and the port bit gives the driven level. The pull-up is on only when three things hold: pull-ups are not disabled globally, the pin is an input, and its port bit is 1.

For test, the slice adds three scan flops to a serial chain. One is a standard cell for the pull-up enable. The other two form a compact pin cell. In that cell, the output-enable, output-data and input-data signals share two stages. A capture strobe loads a snapshot of the pin's live state into the chain. A shift strobe moves the chain by one bit. An update strobe copies the chain into hold latches. When test mode is selected, those latches take over the pad drive and the pull-up. When test mode is off, the latches are ignored.

All flops run on the scan clock `clk_i` and clear asynchronously on `rst_ni`.

Top module: `bsc_bidir_pin`

## Requirements
- R1: With `test_mode_i`=0, `pad_oe_o` equals `dir_bit_i` and `pad_out_o` equals `port_bit_i`. A pad with `pad_oe_o`=0 is high impedance.
- R2: With `test_mode_i`=0, `pullup_en_o` is 1 exactly when `pud_i`=0, `dir_bit_i`=0 and `port_bit_i`=1.
- R3: On a clock edge with `capture_i`=1, the chain loads three values. The pull-up cell takes the current `pullup_en_o`. The control stage takes the current `pad_oe_o`. The data stage takes the raw `pad_in_i`, with no synchronizer.
- R4: On a clock edge with `shift_i`=1 and `capture_i`=0, the chain moves one place. The order is `scan_in_i` → pull-up cell → control stage → data stage → `scan_out_o`. `scan_out_o` is the data-stage flop, so the chain is 3 bits long.
- R5: On a clock edge with `update_i`=1, the chain is copied into the hold latches. The pull-up latch takes the pull-up cell. The output-enable latch takes the control stage. The output-data latch takes the data stage.
- R6: With `test_mode_i`=1, `pad_oe_o`, `pad_out_o` and `pullup_en_o` come from the output-enable, output-data and pull-up latches. `port_bit_i`, `dir_bit_i` and `pud_i` have no effect on them.
- R7: With `test_mode_i`=0, an update changes none of `pad_oe_o`, `pad_out_o` or `pullup_en_o`. The latched values appear once `test_mode_i` goes to 1.
- R8: While `rst_ni`=0, all chain flops and latches are 0.
- R9: When `capture_i` and `shift_i` are both 1, the capture takes place and the shift does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Scan clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| test_mode_i | input | 1 | Latches drive the pad when 1 |
| capture_i | input | 1 | Capture strobe |
| shift_i | input | 1 | Shift strobe |
| update_i | input | 1 | Update strobe |
| scan_in_i | input | 1 | Serial chain input |
| scan_out_o | output | 1 | Serial chain output |
| port_bit_i | input | 1 | Port data register bit |
| dir_bit_i | input | 1 | Direction register bit (1 = output) |
| pud_i | input | 1 | Global pull-up disable |
| pad_in_i | input | 1 | Raw pad level |
| pad_out_o | output | 1 | Level driven on the pad |
| pad_oe_o | output | 1 | Pad driver enable |
| pullup_en_o | output | 1 | Pull-up enable |

## Verification
The bench loads a known pattern into the chain, updates it, and then checks that port, direction and disable changes cannot disturb the pad once test mode is on. A design with the latch multiplexer reversed or missing would let the normal registers leak through. The bench also shifts a capture back out and checks the bit order. A slice with the two pin stages swapped, or with the data stage loaded from a synchronized copy of the pin, shows up in the first bits shifted out. It also drives capture and shift together, and it updates while in normal mode. A design with the strobe priority reversed, or with the latches not gated by test mode, then shows the wrong `scan_out_o` or a pad that changes.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  localparam int unsigned PIN_STAGES = 2;
  localparam int unsigned CHAIN_LEN  = PIN_STAGES + 1;

  typedef struct packed {
    logic oe;
    logic dat;
  } pin_drive_t;
endpackage

// File: rtl/bsc_std_cell.sv
module bsc_std_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic capture_i,
  input  logic shift_i,
  input  logic update_i,
  input  logic cap_d_i,
  input  logic scan_i,
  output logic scan_o,
  output logic upd_o
);
  logic stage_q, upd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= RST_VAL;
    end else if (capture_i) begin
      stage_q <= cap_d_i;
    end else if (shift_i) begin
      stage_q <= scan_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       upd_q <= RST_VAL;
    else if (update_i) upd_q <= stage_q;
  end

  assign scan_o = stage_q;
  assign upd_o  = upd_q;

  a_r7_latch_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_i |=> $stable(upd_q));
  a_r3_pu_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> stage_q == $past(cap_d_i));
endmodule

// File: rtl/bsc_pin_cell.sv
module bsc_pin_cell
  import bsc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       capture_i,
  input  logic       shift_i,
  input  logic       update_i,
  input  logic       pad_in_i,
  input  logic       oe_cap_i,
  input  logic       scan_i,
  output logic       scan_o,
  output pin_drive_t drive_o
);
  // stage_q[1] = control, stage_q[0] = data (chain tail)
  logic [PIN_STAGES-1:0] stage_q;
  pin_drive_t            drive_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else if (capture_i) begin
      stage_q <= {oe_cap_i, pad_in_i};
    end else if (shift_i) begin
      stage_q <= {scan_i, stage_q[PIN_STAGES-1:1]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drive_q <= '0;
    end else if (update_i) begin
      drive_q.oe  <= stage_q[1];
      drive_q.dat <= stage_q[0];
    end
  end

  assign scan_o  = stage_q[0];
  assign drive_o = drive_q;

  a_r3_pin_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> (scan_o == $past(pad_in_i)) && (stage_q[1] == $past(oe_cap_i)));
  a_r4_shift_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !capture_i) |=> (scan_o == $past(stage_q[1])) && (stage_q[1] == $past(scan_i)));
  a_r5_update_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_i |=> (drive_o.oe == $past(stage_q[1])) && (drive_o.dat == $past(stage_q[0])));
endmodule

// File: rtl/bsc_port_mux.sv
module bsc_port_mux
  import bsc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       test_mode_i,
  input  logic       port_bit_i,
  input  logic       dir_bit_i,
  input  logic       pud_i,
  input  pin_drive_t drive_i,
  input  logic       pu_lat_i,
  output logic       pad_out_o,
  output logic       pad_oe_o,
  output logic       pullup_en_o
);
  logic pu_norm;

  always_comb begin
    pu_norm = !pud_i && !dir_bit_i && port_bit_i;
    if (test_mode_i) begin
      pad_oe_o    = drive_i.oe;
      pad_out_o   = drive_i.dat;
      pullup_en_o = pu_lat_i;
    end else begin
      pad_oe_o    = dir_bit_i;
      pad_out_o   = port_bit_i;
      pullup_en_o = pu_norm;
    end
  end

  a_r2_pullup_input_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!test_mode_i && pullup_en_o) |-> (!pad_oe_o && !pud_i));
  a_r6_test_ignores_regs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_mode_i && $past(test_mode_i) && $stable(drive_i) && $stable(pu_lat_i))
      |-> ($stable(pad_oe_o) && $stable(pad_out_o) && $stable(pullup_en_o)));
endmodule

// File: rtl/bsc_bidir_pin.sv
module bsc_bidir_pin
  import bsc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic test_mode_i,
  input  logic capture_i,
  input  logic shift_i,
  input  logic update_i,
  input  logic scan_in_i,
  output logic scan_out_o,
  input  logic port_bit_i,
  input  logic dir_bit_i,
  input  logic pud_i,
  input  logic pad_in_i,
  output logic pad_out_o,
  output logic pad_oe_o,
  output logic pullup_en_o
);
  logic       pu_scan, pu_lat;
  pin_drive_t drive;

  bsc_std_cell #(.RST_VAL(1'b0)) u_pu_cell (
    .clk_i, .rst_ni, .capture_i, .shift_i, .update_i,
    .cap_d_i (pullup_en_o),
    .scan_i  (scan_in_i),
    .scan_o  (pu_scan),
    .upd_o   (pu_lat)
  );

  bsc_pin_cell u_pin_cell (
    .clk_i, .rst_ni, .capture_i, .shift_i, .update_i,
    .pad_in_i,
    .oe_cap_i (pad_oe_o),
    .scan_i   (pu_scan),
    .scan_o   (scan_out_o),
    .drive_o  (drive)
  );

  bsc_port_mux u_mux (
    .clk_i, .rst_ni, .test_mode_i, .port_bit_i, .dir_bit_i, .pud_i,
    .drive_i  (drive),
    .pu_lat_i (pu_lat),
    .pad_out_o, .pad_oe_o, .pullup_en_o
  );

  a_r8_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |-> (!scan_out_o && !pu_scan && !pu_lat && (drive == '0)));
endmodule

// File: tb/bsc_bidir_pin_tb_top.sv
module bsc_bidir_pin_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tm = 0, cap = 0, sh = 0, up = 0, si = 0;
  logic port = 0, dir = 0, pud = 0, pad = 0;
  logic so, pout, poe, pu;
  int total = 0, bad = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bsc_bidir_pin dut_i (
    .clk_i(clk), .rst_ni(rst_n), .test_mode_i(tm), .capture_i(cap), .shift_i(sh),
    .update_i(up), .scan_in_i(si), .scan_out_o(so), .port_bit_i(port), .dir_bit_i(dir),
    .pud_i(pud), .pad_in_i(pad), .pad_out_o(pout), .pad_oe_o(poe), .pullup_en_o(pu)
  );

  // reference model: q[0]=pull-up cell, q[1]=control, q[2]=data
  bit q[$] = '{1'b0, 1'b0, 1'b0};
  bit l_pu = 0, l_oe = 0, l_od = 0;

  function automatic bit m_oe();  return tm ? l_oe : dir; endfunction
  function automatic bit m_out(); return tm ? l_od : port; endfunction
  function automatic bit m_pu();  return tm ? l_pu : (!pud && !dir && port); endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q = '{1'b0, 1'b0, 1'b0}; l_pu = 0; l_oe = 0; l_od = 0;
    end else begin
      bit c_pu, c_oe;
      c_pu = m_pu(); c_oe = m_oe();
      if (up) begin l_pu = q[0]; l_oe = q[1]; l_od = q[2]; end
      if (cap) q = '{c_pu, c_oe, pad};
      else if (sh) begin q.push_front(si); void'(q.pop_back()); end
    end
  end

  task automatic check(string req, logic got, logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check(tm ? "R6 oe" : "R1 oe", poe, m_oe());
      check(tm ? "R6 out" : "R1 out", pout, m_out());
      check(tm ? "R6 pu" : "R2 pu", pu, m_pu());
      check("R4 scan_out", so, q[2]);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic cyc(bit t, bit c, bit s, bit u, bit i, bit p, bit d, bit pd, bit pa);
    @(negedge clk); #1;
    tm = t; cap = c; sh = s; up = u; si = i; port = p; dir = d; pud = pd; pad = pa;
  endtask

  task automatic after_edge();
    @(posedge clk); #1;
  endtask

  initial begin
    #(CLK_PERIOD*3 + 1);
    check("R8 scan_out", so, 1'b0);
    check("R8 oe", poe, 1'b0);
    check("R8 pu", pu, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    for (int k = 0; k < 8; k++) begin
      cyc(0, 0, 0, 0, 0, k[0], k[1], k[2], 0);
      after_edge();
      check("R1 oe sweep", poe, k[1]);
      check("R2 pu sweep", pu, !k[2] && !k[1] && k[0]);
    end

    // R3: capture oe=1 pu=0 pad=1, then shift out
    cyc(0, 1, 0, 0, 0, 1, 1, 0, 1); after_edge();
    check("R3 data stage", so, 1'b1);
    cyc(0, 0, 1, 0, 0, 1, 1, 0, 0); after_edge();
    check("R3 control stage", so, 1'b1);
    cyc(0, 0, 1, 0, 0, 1, 1, 0, 0); after_edge();
    check("R3 pull-up cell", so, 1'b0);

    // R5: load pu=1 oe=1 od=0, update in normal mode
    cyc(0, 0, 1, 0, 0, 0, 0, 1, 0);
    cyc(0, 0, 1, 0, 1, 0, 0, 1, 0);
    cyc(0, 0, 1, 0, 1, 0, 0, 1, 0);
    cyc(0, 0, 0, 1, 0, 0, 0, 1, 0); after_edge();
    check("R7 oe unchanged", poe, 1'b0);
    check("R7 pu unchanged", pu, 1'b0);
    cyc(1, 0, 0, 0, 0, 1, 0, 1, 0); after_edge();
    check("R5 oe latch", poe, 1'b1);
    check("R5 od latch", pout, 1'b0);
    check("R5 pu latch", pu, 1'b1);
    cyc(1, 0, 0, 0, 0, 0, 1, 0, 1); after_edge();
    check("R6 oe ignores dir", poe, 1'b1);
    check("R6 out ignores port", pout, 1'b0);
    check("R6 pu ignores pud", pu, 1'b1);
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0); after_edge();
    check("R7 back to normal oe", poe, 1'b0);
    check("R7 back to normal pu", pu, 1'b1);

    // R9: capture with shift
    cyc(0, 1, 1, 0, 0, 0, 1, 0, 1); after_edge();
    check("R9 capture wins", so, 1'b1);
    cyc(0, 0, 1, 0, 0, 0, 1, 0, 0); after_edge();
    check("R9 control captured", so, 1'b1);

    for (int n = 0; n < 400; n++) begin
      bit [9:0] r;
      r = 10'($urandom);
      cyc(r[0], r[1] & r[2], r[3], r[4], r[5], r[6], r[7], r[8], r[9]);
    end

    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk); #1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule